// File: doc/BRIEF.md
# Next-PC Selection Unit

This unit owns the program counter of a 32-bit RISC core and works out, every cycle, which address the core fetches next. It takes the current instruction word, the zero flag produced by comparing the two source registers, and the value of one source register. From these it chooses one of six flow kinds: sequential, branch-if-equal, branch-if-not-equal, absolute jump, call, or register jump. It then loads the chosen address into the PC on the next rising clock edge.

Calls also produce a return address and a write request aimed at the link register. The register file writes that value in the same cycle that the PC is redirected. The flow kinds are the decoder's states, and each cycle selects exactly one of them. FLOW_SEQ is the fall-through kind. FLOW_BEQ and FLOW_BNE each choose between the fall-through address and a PC-relative target. FLOW_JUMP and FLOW_CALL select a region-relative target. FLOW_REGJ selects the register value. The PC itself moves from reset to running and then changes once per clock.

Top module: `pc_sequencer`

## Requirements
- R1: While `rst` is high at a rising edge, `pc_q` is loaded with 0 on that edge, whatever the instruction.
- R2: An instruction whose opcode (bits 31:26) is none of 0x02, 0x03, 0x04, 0x05 advances `pc_q` by 4. The same holds for opcode 0x00 with a function field (bits 5:0) other than 0x08.
- R3: Opcode 0x04 (branch-if-equal) with `zero_flag` = 1 loads pc+4 + (sign-extended bits 15:0) × 4. With `zero_flag` = 0 it loads pc+4.
- R4: Opcode 0x05 (branch-if-not-equal) takes the same target when `zero_flag` = 0. With `zero_flag` = 1 it loads pc+4.
- R5: The 16-bit branch offset is two's complement, so offsets with bit 15 set move the PC backwards.
- R6: Opcode 0x02 (jump) loads {pc+4 [31:28], instr[25:0], 2'b00}.
- R7: Opcode 0x03 (call) loads the same target as R6. In the same cycle it drives `link_we` = 1, `link_value` = pc+4 and `link_addr` = 31.
- R8: Opcode 0x00 with function field 0x08 (register jump) loads `reg_value` unchanged into `pc_q`.
- R9: `link_we` is 0 for every instruction other than opcode 0x03. `link_value` always shows pc+4, and `link_addr` always shows 31.
- R10: The upper four PC bits used for a jump or call come from pc+4. A jump placed in the last word of a 256 MB region therefore lands in the following region.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| instr | input | 32 | Instruction word at the current PC |
| zero_flag | input | 1 | 1 when the two compared source registers are equal |
| reg_value | input | 32 | Source register value used by register jumps |
| pc_q | output | 32 | Current program counter |
| link_value | output | 32 | Return address (pc+4) |
| link_we | output | 1 | Write request for the link register |
| link_addr | output | 5 | Index of the link register (31) |

## Verification
A call redirects the PC and requests the link-register write in one cycle. The link value must be the old pc+4, and the redirected PC must be the jump target. The bench issues calls back to back, and also directly after register jumps that place the PC at a region's last word. In that same cycle it compares the combinational link outputs with the model. It then compares the registered PC after the edge, so a link value or region bits taken from the wrong side of the edge show up as a mismatch. A reset asserted while a call instruction is presented checks that reset wins over the redirect.

// File: rtl/pc_sequencer_pkg.sv
package pc_sequencer_pkg;

    typedef enum logic [2:0] {
        FLOW_SEQ,
        FLOW_BEQ,
        FLOW_BNE,
        FLOW_JUMP,
        FLOW_CALL,
        FLOW_REGJ
    } flow_e;

    localparam int OPC_W   = 6;
    localparam int FUNCT_W = 6;

    localparam logic [OPC_W-1:0]   OPC_SPECIAL = 6'h00;
    localparam logic [OPC_W-1:0]   OPC_JUMP    = 6'h02;
    localparam logic [OPC_W-1:0]   OPC_CALL    = 6'h03;
    localparam logic [OPC_W-1:0]   OPC_BEQ     = 6'h04;
    localparam logic [OPC_W-1:0]   OPC_BNE     = 6'h05;
    localparam logic [FUNCT_W-1:0] FN_REGJ     = 6'h08;

endpackage

// File: rtl/pc_flow_decode.sv
module pc_flow_decode
    import pc_sequencer_pkg::*;
(
    input  logic [OPC_W-1:0]   opcode,
    input  logic [FUNCT_W-1:0] funct,
    output flow_e              kind
);

    always_comb begin
        unique case (opcode)
            OPC_SPECIAL: kind = (funct == FN_REGJ) ? FLOW_REGJ : FLOW_SEQ;
            OPC_JUMP:    kind = FLOW_JUMP;
            OPC_CALL:    kind = FLOW_CALL;
            OPC_BEQ:     kind = FLOW_BEQ;
            OPC_BNE:     kind = FLOW_BNE;
            default:     kind = FLOW_SEQ;
        endcase
    end

endmodule

// File: rtl/pc_target_calc.sv
module pc_target_calc
    import pc_sequencer_pkg::*;
#(
    parameter int AW   = 32,
    parameter int OFFW = 16,
    parameter int JW   = 26
) (
    input  logic [AW-1:0]   pc,
    input  logic [OFFW-1:0] offset,
    input  logic [JW-1:0]   jindex,
    input  logic [AW-1:0]   reg_value,
    input  logic            zero_flag,
    input  flow_e           kind,
    output logic [AW-1:0]   seq_pc,
    output logic [AW-1:0]   next_pc
);

    localparam int EXTW   = AW - OFFW - 2;
    localparam int REGION = AW - JW - 2;

    logic [AW-1:0] branch_pc;
    logic [AW-1:0] jump_pc;

    assign seq_pc    = pc + AW'(4);
    assign branch_pc = seq_pc + {{EXTW{offset[OFFW-1]}}, offset, 2'b00};
    assign jump_pc   = {seq_pc[AW-1 -: REGION], jindex, 2'b00};

    always_comb begin
        unique case (kind)
            FLOW_SEQ:  next_pc = seq_pc;
            FLOW_BEQ:  next_pc = zero_flag ? branch_pc : seq_pc;
            FLOW_BNE:  next_pc = zero_flag ? seq_pc : branch_pc;
            FLOW_JUMP: next_pc = jump_pc;
            FLOW_CALL: next_pc = jump_pc;
            FLOW_REGJ: next_pc = reg_value;
            default:   next_pc = seq_pc;
        endcase
    end

endmodule

// File: rtl/pc_sequencer.sv
module pc_sequencer
    import pc_sequencer_pkg::*;
#(
    parameter int          AW       = 32,
    parameter int          RIDX_W   = 5,
    parameter int          LINK_REG = 31,
    parameter logic [31:0] RESET_PC = 32'h0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [31:0]       instr,
    input  logic              zero_flag,
    input  logic [AW-1:0]     reg_value,
    output logic [AW-1:0]     pc_q,
    output logic [AW-1:0]     link_value,
    output logic              link_we,
    output logic [RIDX_W-1:0] link_addr
);

    localparam int OFFW = 16;
    localparam int JW   = 26;

    flow_e         kind;
    logic [AW-1:0] seq_pc;
    logic [AW-1:0] next_pc;

    pc_flow_decode u_decode (
        .opcode (instr[31:26]),
        .funct  (instr[5:0]),
        .kind   (kind)
    );

    pc_target_calc #(
        .AW   (AW),
        .OFFW (OFFW),
        .JW   (JW)
    ) u_target (
        .pc        (pc_q),
        .offset    (instr[OFFW-1:0]),
        .jindex    (instr[JW-1:0]),
        .reg_value (reg_value),
        .zero_flag (zero_flag),
        .kind      (kind),
        .seq_pc    (seq_pc),
        .next_pc   (next_pc)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q <= RESET_PC[AW-1:0];
        end else begin
            pc_q <= next_pc;
        end
    end

    always_comb begin
        link_value = seq_pc;
        link_addr  = RIDX_W'(LINK_REG);
        link_we    = (kind == FLOW_CALL);
    end

endmodule

// File: rtl/pc_sequencer_chk.sv
module pc_sequencer_chk (
    input logic        clk,
    input logic        rst,
    input logic [31:0] instr,
    input logic        zero_flag,
    input logic [31:0] reg_value,
    input logic [31:0] pc_q,
    input logic [31:0] link_value,
    input logic        link_we,
    input logic [4:0]  link_addr
);

    logic [5:0]  op;
    logic        is_regj;
    logic        is_plain;
    logic [31:0] boff;
    logic [31:0] jtgt;

    assign op       = instr[31:26];
    assign is_regj  = (op == 6'd0) && (instr[5:0] == 6'd8);
    assign is_plain = (op != 6'd2) && (op != 6'd3) && (op != 6'd4)
                      && (op != 6'd5) && !is_regj;
    assign boff     = 32'($signed(instr[15:0])) <<< 2;
    assign jtgt     = ((pc_q + 32'd4) & 32'hF000_0000) | {4'h0, instr[25:0], 2'b00};

    AST_RESET_PC: assert property (@(posedge clk) rst |=> pc_q == 32'h0); // R1

    AST_SEQ_ADVANCE: assert property (@(posedge clk) disable iff (rst)
        is_plain |=> pc_q == $past(pc_q) + 32'd4); // R2

    AST_BEQ_TAKEN: assert property (@(posedge clk) disable iff (rst)
        (op == 6'd4 && zero_flag) |=> pc_q == $past(pc_q) + 32'd4 + $past(boff)); // R3

    AST_BNE_TAKEN: assert property (@(posedge clk) disable iff (rst)
        (op == 6'd5 && !zero_flag) |=> pc_q == $past(pc_q) + 32'd4 + $past(boff)); // R4

    AST_JUMP_TARGET: assert property (@(posedge clk) disable iff (rst)
        (op == 6'd2 || op == 6'd3) |=> pc_q == $past(jtgt)); // R6

    AST_REGJ_TARGET: assert property (@(posedge clk) disable iff (rst)
        is_regj |=> pc_q == $past(reg_value)); // R8

    AST_LINK_ONLY_CALL: assert property (@(posedge clk) disable iff (rst)
        link_we == (op == 6'd3)); // R9

    AST_LINK_VALUE: assert property (@(posedge clk) disable iff (rst)
        link_we |-> (link_value == pc_q + 32'd4 && link_addr == 5'd31)); // R7

endmodule

bind pc_sequencer pc_sequencer_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .instr      (instr),
    .zero_flag  (zero_flag),
    .reg_value  (reg_value),
    .pc_q       (pc_q),
    .link_value (link_value),
    .link_we    (link_we),
    .link_addr  (link_addr)
);

// File: tb/test_pc_sequencer.sv
`timescale 1ns/1ps
module test_pc_sequencer;

    localparam time TCLK = 8ns;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] instr = 32'h0;
    logic        zero_flag = 1'b0;
    logic [31:0] reg_value = 32'h0;
    logic [31:0] pc_q;
    logic [31:0] link_value;
    logic        link_we;
    logic [4:0]  link_addr;

    int checks = 0;
    int fails  = 0;
    logic [31:0] model_pc = 32'h0;

    always #(TCLK/2) clk = ~clk;

    pc_sequencer i_pc_sequencer (
        .clk        (clk),
        .rst        (rst),
        .instr      (instr),
        .zero_flag  (zero_flag),
        .reg_value  (reg_value),
        .pc_q       (pc_q),
        .link_value (link_value),
        .link_we    (link_we),
        .link_addr  (link_addr)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %08h expected %08h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] ref_next(input logic [31:0] pc, input logic [31:0] w,
                                             input logic z, input logic [31:0] rv);
        int op;
        int off;
        logic [31:0] after;
        op    = int'(w[31:26]);
        off   = int'($signed(w[15:0]));
        after = pc + 32'd4;
        if (op == 4 && z)                        return after + 32'(off * 4);
        if (op == 5 && !z)                       return after + 32'(off * 4);
        if (op == 2 || op == 3)                  return (after & 32'hF000_0000) | (32'(w[25:0]) << 2);
        if (op == 0 && int'(w[5:0]) == 8)        return rv;
        return after;
    endfunction

    task automatic step(input logic [31:0] w, input logic z, input logic [31:0] rv, input string req);
        logic [31:0] nxt;
        instr = w; zero_flag = z; reg_value = rv;
        #1;
        check("R9 link_we", 32'(link_we), 32'(w[31:26] == 6'd3));
        check("R7 link_value", link_value, model_pc + 32'd4);
        check("R7 link_addr", 32'(link_addr), 32'd31);
        nxt = ref_next(model_pc, w, z, rv);
        @(posedge clk);
        @(negedge clk);
        model_pc = nxt;
        check(req, pc_q, model_pc);
    endtask

    function automatic logic [31:0] mk_i(input int op, input logic [25:0] rest);
        return {6'(op), rest};
    endfunction

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        #(TCLK * 200000);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 reset", pc_q, 32'h0);
        rst = 1'b0;
        model_pc = 32'h0;

        step(32'h0000_0000, 1'b0, 32'h0, "R2 nop");
        step(32'h0232_4020, 1'b0, 32'h0, "R2 reg op");
        step(mk_i(6'h23, 26'h0000010), 1'b1, 32'h0, "R2 load");
        step(32'h0000_0009, 1'b0, 32'h1234_5678, "R2 funct 0x09");
        step(mk_i(4, 26'h0000005), 1'b1, 32'h0, "R3 beq taken");
        step(mk_i(4, 26'h0000005), 1'b0, 32'h0, "R3 beq not taken");
        step(mk_i(5, 26'h0000003), 1'b0, 32'h0, "R4 bne taken");
        step(mk_i(5, 26'h0000003), 1'b1, 32'h0, "R4 bne not taken");
        step(mk_i(4, 26'h000FFFE), 1'b1, 32'h0, "R5 backward beq");
        step(mk_i(5, 26'h0008000), 1'b0, 32'h0, "R5 min offset bne");
        step(mk_i(2, 26'h0000400), 1'b0, 32'h0, "R6 jump");
        step(mk_i(3, 26'h0000800), 1'b0, 32'h0, "R7 call");
        step(32'h0000_0008, 1'b0, 32'h0FFF_FFFC, "R8 register jump");
        step(mk_i(2, 26'h0000010), 1'b0, 32'h0, "R10 region crossing jump");
        step(32'h0000_0008, 1'b1, 32'h3FFF_FFFC, "R8 register jump");
        step(mk_i(3, 26'h3FFFFFF), 1'b0, 32'h0, "R10 region crossing call");
        step(mk_i(3, 26'h0000020), 1'b0, 32'h0, "R7 back-to-back call");

        rst = 1'b1;
        instr = mk_i(3, 26'h0000040);
        @(posedge clk);
        @(negedge clk);
        check("R1 reset over call", pc_q, 32'h0);
        rst = 1'b0;
        model_pc = 32'h0;

        for (int n = 0; n < 400; n++) begin
            int sel;
            logic [31:0] w;
            sel = int'($urandom_range(0, 6));
            w   = $urandom;
            case (sel)
                0: w[31:26] = 6'h04;
                1: w[31:26] = 6'h05;
                2: w[31:26] = 6'h02;
                3: w[31:26] = 6'h03;
                4: begin w[31:26] = 6'h00; w[5:0] = 6'h08; end
                5: w[31:26] = 6'h00;
                default: w[31:26] = 6'h08;
            endcase
            step(w, 1'($urandom), {$urandom} & 32'hFFFF_FFFC, "R2-random mix");
        end

        finish_run();
    end

endmodule